// File: doc/BRIEF.md
# Masked Bit Test Execution Unit

This unit carries out one instruction of an 8-bit microcontroller core: a bit test that inverts a destination byte, ANDs it with a mask byte and reports the outcome only through the flag register. The opcode and its operand bytes arrive one byte per transfer on a valid/ready stream. The unit decodes six addressing forms, resolves the operand addresses against its own 4096-byte register file, reads the operands, updates the flags and raises a one-cycle completion pulse. No register file location is ever written by an instruction.

Register addresses are 12 bits wide. An 8-bit register address is extended with the low nibble of the register-pointer input. A nibble-sized working-register number is placed inside the group named by the pointer's high nibble. A load port, a flag load port and a combinational peek port let the surrounding core (or a bench) preload state and observe it.

Top module: `masked_bit_test`

## Requirements
- R1: On completion, result = (NOT dst) AND mask, and flag bit 6 (zero) is 1 exactly when the 8-bit result is 0, which means all masked destination bits were 1.
- R2: Flag bit 5 (sign) takes bit 7 of the result.
- R3: Flag bit 4 (overflow) is 0 after every completed instruction.
- R4: Flag bits 7 (carry), 3 (decimal adjust), 2 (half carry), 1 and 0 keep their previous values through an instruction.
- R5: No instruction changes any register file byte: destination, mask source and pointer locations read back unchanged through the peek port.
- R6: Opcode 0x62 takes one operand byte whose high nibble is the destination working register and low nibble the mask working register. Opcode 0x63 is the same, but the low-nibble working register holds a pointer to the mask.
- R7: Opcodes 0x64 and 0x65 take two bytes: the first is the mask register (0x65: a register holding a pointer to the mask) and the second the destination register. Opcodes 0x66 and 0x67 take the destination register (0x67: a register holding a pointer to the destination) and then an immediate mask.
- R8: With pointer input rp, working register n maps to address {rp[3:0], rp[7:4], n}. An 8-bit register field A maps to {rp[3:0], A}, except that a field with high nibble 0xE maps to working register A[3:0].
- R9: A pointer byte P fetched for an indirect form addresses {rp[3:0], P} with no escape decoding, so P = 0xE0..0xEF reaches those plain locations.
- R10: An opcode byte outside 0x62..0x67 is consumed, produces no completion pulse and no flag change, and the next byte is taken as an opcode.
- R11: done_o is high for exactly one cycle per instruction. flags_o shows the new flags in that cycle and changes at no other time except through the flag load port. ins_ready_o is low in the cycle before done_o.
- R12: After reset flags_o is 0, done_o is 0 and ins_ready_o is 1. flag_we_i loads flags_o on the next edge, and ld_we_i writes one register file byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rp_i | input | 8 | Register pointer: [7:4] working group, [3:0] bank prefix |
| ins_valid_i | input | 1 | Instruction byte valid |
| ins_byte_i | input | 8 | Instruction byte (opcode, then operands) |
| ins_ready_o | output | 1 | Unit can take an instruction byte |
| ld_we_i | input | 1 | Register file load strobe |
| ld_addr_i | input | 12 | Register file load address |
| ld_data_i | input | 8 | Register file load data |
| peek_addr_i | input | 12 | Register file observation address |
| peek_data_o | output | 8 | Register file byte at peek_addr_i (combinational) |
| flag_we_i | input | 1 | Flag register load strobe |
| flag_data_i | input | 8 | Flag register load value |
| flags_o | output | 8 | Flag register |
| done_o | output | 1 | One-cycle pulse when the flags are updated |

## Verification
A wrong decode of an opcode or a misplaced operand byte resolves the wrong address. It shows up in the completion cycle as zero or sign flags that differ from the value computed from the stored bytes. A stray write from the datapath would show on the peek port, which is read right after each completion pulse at the destination, mask and pointer locations. A stuck state in the sequencer shows as a missing or extra done pulse, or as ins_ready_o held low, within a few cycles of the last operand byte. A flag mux fault shows on the preserved bits 7, 3, 2, 1 and 0 in that same cycle.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned BANK_W = 4;
  localparam int unsigned ADDR_W = BANK_W + DATA_W;
  localparam logic [3:0]  ESC_NIB = 4'hE;

  // flag register bit positions
  localparam int unsigned FLG_C = 7;
  localparam int unsigned FLG_Z = 6;
  localparam int unsigned FLG_S = 5;
  localparam int unsigned FLG_V = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP1,
    ST_OP2,
    ST_PTR,
    ST_EXEC
  } tcm_state_e;

  typedef enum logic [1:0] {
    AM_WORK,   // nibble selects a working register
    AM_REG,    // byte address with escape decoding
    AM_PTR     // pointer value, bank prefix only
  } tcm_amode_e;

  typedef struct packed {
    logic legal;
    logic one_byte;   // single operand byte carrying two nibbles
    logic src_first;  // first operand byte names the mask source
    logic src_ind;    // mask reached through a pointer
    logic dst_ind;    // destination reached through a pointer
    logic src_imm;    // mask is the second operand byte
  } tcm_form_t;

endpackage

// File: rtl/tcm_decode.sv
module tcm_decode
  import tcm_pkg::*;
(
  input  logic [DATA_W-1:0] opcode_i,
  output tcm_form_t         form_o
);

  always_comb begin
    form_o = '0;
    unique case (opcode_i)
      8'h62: begin form_o.legal = 1'b1; form_o.one_byte = 1'b1; end
      8'h63: begin form_o.legal = 1'b1; form_o.one_byte = 1'b1; form_o.src_ind = 1'b1; end
      8'h64: begin form_o.legal = 1'b1; form_o.src_first = 1'b1; end
      8'h65: begin form_o.legal = 1'b1; form_o.src_first = 1'b1; form_o.src_ind = 1'b1; end
      8'h66: begin form_o.legal = 1'b1; form_o.src_imm = 1'b1; end
      8'h67: begin form_o.legal = 1'b1; form_o.src_imm = 1'b1; form_o.dst_ind = 1'b1; end
      default: form_o = '0;
    endcase
  end

endmodule

// File: rtl/tcm_addr_map.sv
module tcm_addr_map
  import tcm_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned BW  = BANK_W,
  parameter logic [3:0]  ESC = ESC_NIB
) (
  input  logic [DW-1:0]    rp_i,
  input  tcm_amode_e       mode_i,
  input  logic [DW-1:0]    field_i,
  output logic [BW+DW-1:0] addr_o
);

  localparam int unsigned NIB_W = DW / 2;

  logic [BW-1:0]    bank;
  logic [NIB_W-1:0] group;
  logic [BW+DW-1:0] work_addr;
  logic [BW+DW-1:0] plain_addr;

  assign bank       = rp_i[BW-1:0];
  assign group      = rp_i[DW-1 -: NIB_W];
  assign work_addr  = {bank, group, field_i[NIB_W-1:0]};
  assign plain_addr = {bank, field_i};

  always_comb begin
    unique case (mode_i)
      AM_WORK: addr_o = work_addr;
      AM_REG:  addr_o = (field_i[DW-1 -: NIB_W] == ESC) ? work_addr : plain_addr;
      default: addr_o = plain_addr;
    endcase
  end

endmodule

// File: rtl/tcm_regfile.sv
module tcm_regfile #(
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 12,
  parameter int unsigned NRD = 4
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
  end

endmodule

// File: rtl/masked_bit_test.sv
module masked_bit_test
  import tcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rp_i,
  input  logic              ins_valid_i,
  input  logic [7:0]        ins_byte_i,
  output logic              ins_ready_o,
  input  logic              ld_we_i,
  input  logic [11:0]       ld_addr_i,
  input  logic [7:0]        ld_data_i,
  input  logic [11:0]       peek_addr_i,
  output logic [7:0]        peek_data_o,
  input  logic              flag_we_i,
  input  logic [7:0]        flag_data_i,
  output logic [7:0]        flags_o,
  output logic              done_o
);

  localparam int unsigned NLANE  = 3;   // 0: pointer location, 1: destination, 2: mask source
  localparam int unsigned NRD    = NLANE + 1;
  localparam int unsigned PEEK_P = 0;

  // reset synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  // state
  tcm_state_e          state_q, state_d;
  logic [DATA_W-1:0]   op_q, b1_q, b2_q, ptr_q;
  logic [DATA_W-1:0]   flags_q, flags_d;
  logic                done_q, done_d;
  logic                op_en, b1_en, b2_en, ptr_en, flags_en;

  tcm_form_t           form;
  logic [DATA_W-1:0]   dec_in;
  logic                accept;

  tcm_amode_e          lane_mode [NLANE];
  logic [DATA_W-1:0]   lane_field [NLANE];
  logic [ADDR_W-1:0]   lane_addr [NLANE];

  logic [NRD-1:0][ADDR_W-1:0] rd_addr;
  logic [NRD-1:0][DATA_W-1:0] rd_data;

  logic [DATA_W-1:0]   dst_val, mask_val, result;
  logic [DATA_W-1:0]   exec_flags;

  assign ins_ready_o = (state_q == ST_IDLE) || (state_q == ST_OP1) || (state_q == ST_OP2);
  assign accept      = ins_valid_i && ins_ready_o;
  assign dec_in      = (state_q == ST_IDLE) ? ins_byte_i : op_q;

  tcm_decode u_dec (
    .opcode_i (dec_in),
    .form_o   (form)
  );

  // operand lane selection
  always_comb begin
    // pointer location
    if (form.one_byte) begin
      lane_mode[0]  = AM_WORK;
      lane_field[0] = {4'h0, b1_q[3:0]};
    end else begin
      lane_mode[0]  = AM_REG;
      lane_field[0] = b1_q;
    end
    // destination
    if (form.one_byte) begin
      lane_mode[1]  = AM_WORK;
      lane_field[1] = {4'h0, b1_q[7:4]};
    end else if (form.dst_ind) begin
      lane_mode[1]  = AM_PTR;
      lane_field[1] = ptr_q;
    end else if (form.src_first) begin
      lane_mode[1]  = AM_REG;
      lane_field[1] = b2_q;
    end else begin
      lane_mode[1]  = AM_REG;
      lane_field[1] = b1_q;
    end
    // mask source (unused for immediate forms)
    if (form.src_ind) begin
      lane_mode[2]  = AM_PTR;
      lane_field[2] = ptr_q;
    end else if (form.one_byte) begin
      lane_mode[2]  = AM_WORK;
      lane_field[2] = {4'h0, b1_q[3:0]};
    end else begin
      lane_mode[2]  = AM_REG;
      lane_field[2] = b1_q;
    end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    tcm_addr_map u_map (
      .rp_i    (rp_i),
      .mode_i  (lane_mode[l]),
      .field_i (lane_field[l]),
      .addr_o  (lane_addr[l])
    );
    assign rd_addr[l+1] = lane_addr[l];
  end
  assign rd_addr[PEEK_P] = peek_addr_i;

  tcm_regfile #(
    .DW  (DATA_W),
    .AW  (ADDR_W),
    .NRD (NRD)
  ) u_rf (
    .clk     (clk),
    .we_i    (ld_we_i),
    .waddr_i (ld_addr_i),
    .wdata_i (ld_data_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  assign peek_data_o = rd_data[PEEK_P];

  // evaluation
  assign dst_val  = rd_data[2];
  assign mask_val = form.src_imm ? b2_q : rd_data[3];
  assign result   = ~dst_val & mask_val;

  always_comb begin
    exec_flags        = flags_q;
    exec_flags[FLG_Z] = (result == '0);
    exec_flags[FLG_S] = result[DATA_W-1];
    exec_flags[FLG_V] = 1'b0;
  end

  // next state
  always_comb begin
    state_d  = state_q;
    op_en    = 1'b0;
    b1_en    = 1'b0;
    b2_en    = 1'b0;
    ptr_en   = 1'b0;
    done_d   = 1'b0;
    flags_en = 1'b0;
    flags_d  = flags_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          op_en = 1'b1;
          if (form.legal) state_d = ST_OP1;
        end
      end
      ST_OP1: begin
        if (accept) begin
          b1_en = 1'b1;
          if (form.one_byte) state_d = form.src_ind ? ST_PTR : ST_EXEC;
          else               state_d = ST_OP2;
        end
      end
      ST_OP2: begin
        if (accept) begin
          b2_en   = 1'b1;
          state_d = (form.src_ind || form.dst_ind) ? ST_PTR : ST_EXEC;
        end
      end
      ST_PTR: begin
        ptr_en  = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        flags_en = 1'b1;
        flags_d  = exec_flags;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!flags_en && flag_we_i) begin
      flags_en = 1'b1;
      flags_d  = flag_data_i;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (flags_en) flags_q <= flags_d;
    end
  end

  // operand registers
  always_ff @(posedge clk) begin
    if (op_en)  op_q  <= ins_byte_i;
    if (b1_en)  b1_q  <= ins_byte_i;
    if (b2_en)  b2_q  <= ins_byte_i;
    if (ptr_en) ptr_q <= rd_data[1];
  end

  assign flags_o = flags_q;
  assign done_o  = done_q;

endmodule

module masked_bit_test_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done_o,
  input logic       ins_ready_o,
  input logic       flag_we_i,
  input logic [7:0] flags_o
);

  p_vclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !flags_o[4]);

  p_zs_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && flags_o[6]) |-> !flags_o[5]);

  p_keep_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(flag_we_i)) |->
      ({flags_o[7], flags_o[3:0]} == {$past(flags_o[7]), $past(flags_o[3:0])}));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$past(flag_we_i)) |-> $stable(flags_o));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !$past(ins_ready_o));

endmodule

bind masked_bit_test masked_bit_test_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .ins_ready_o (ins_ready_o),
  .flag_we_i   (flag_we_i),
  .flags_o     (flags_o)
);

// File: tb/masked_bit_test_test.sv
`timescale 1ns/1ps
module masked_bit_test_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rp_i;
  logic        ins_valid_i;
  logic [7:0]  ins_byte_i;
  logic        ins_ready_o;
  logic        ld_we_i;
  logic [11:0] ld_addr_i;
  logic [7:0]  ld_data_i;
  logic [11:0] peek_addr_i;
  logic [7:0]  peek_data_o;
  logic        flag_we_i;
  logic [7:0]  flag_data_i;
  logic [7:0]  flags_o;
  logic        done_o;

  always #2 clk = ~clk;

  masked_bit_test uut (.*);

  typedef struct {
    logic [7:0]  flags;
    logic [11:0] a_dst, a_src, a_ptr;
    logic [7:0]  v_dst, v_src, v_ptr;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [7:0]  model [4096];
  logic [7:0]  exp_flags;
  int          checks = 0;
  int          errors = 0;
  int          ndone  = 0;
  int          nops   = 0;
  bit          mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [11:0] wreg(input logic [3:0] n);
    return {rp_i[3:0], rp_i[7:4], n};
  endfunction
  function automatic logic [11:0] rreg(input logic [7:0] a);
    return (a[7:4] == 4'hE) ? wreg(a[3:0]) : {rp_i[3:0], a};
  endfunction
  function automatic logic [11:0] preg(input logic [7:0] p);
    return {rp_i[3:0], p};
  endfunction

  task automatic send(input logic [7:0] b);
    ins_valid_i = 1'b1;
    ins_byte_i  = b;
    while (!ins_ready_o) @(negedge clk);
    @(negedge clk);
    ins_valid_i = 1'b0;
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    ld_we_i = 1'b1; ld_addr_i = a; ld_data_i = d; model[a] = d;
    @(negedge clk);
    ld_we_i = 1'b0;
  endtask

  task automatic load_flags(input logic [7:0] f);
    flag_we_i = 1'b1; flag_data_i = f;
    @(negedge clk);
    flag_we_i = 1'b0;
    exp_flags = f;
    chk(flags_o == f, "R12", "flag load", flags_o, f);
  endtask

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  // driver: computes the expectation, queues it, then streams the bytes
  task automatic run_op(input logic [7:0] op, input logic [7:0] b1,
                        input logic [7:0] b2, input string tag);
    exp_t e;
    logic [11:0] d, s, p;
    logic [7:0]  mask, res;
    case (op)
      8'h62: begin d = wreg(b1[7:4]); s = wreg(b1[3:0]); p = d; mask = model[s]; end
      8'h63: begin d = wreg(b1[7:4]); p = wreg(b1[3:0]); s = preg(model[p]); mask = model[s]; end
      8'h64: begin s = rreg(b1); d = rreg(b2); p = d; mask = model[s]; end
      8'h65: begin p = rreg(b1); s = preg(model[p]); d = rreg(b2); mask = model[s]; end
      8'h66: begin d = rreg(b1); s = d; p = d; mask = b2; end
      default: begin p = rreg(b1); d = preg(model[p]); s = d; mask = b2; end
    endcase
    res = ~model[d] & mask;
    exp_flags[6] = (res == 8'h00);
    exp_flags[5] = res[7];
    exp_flags[4] = 1'b0;
    e.flags = exp_flags;
    e.a_dst = d; e.a_src = s; e.a_ptr = p;
    e.v_dst = model[d]; e.v_src = model[s]; e.v_ptr = model[p];
    e.tag = tag;
    q.push_back(e);
    nops++;
    send(op);
    send(b1);
    if (op != 8'h62 && op != 8'h63) send(b2);
    drain();
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && done_o) begin
      exp_t e;
      ndone++;
      if (q.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 1, 0);
      end else begin
        e = q.pop_front();
        chk(flags_o[6] == e.flags[6], "R1", {e.tag, " zero flag"}, flags_o[6], e.flags[6]);
        chk(flags_o[5] == e.flags[5], "R2", {e.tag, " sign flag"}, flags_o[5], e.flags[5]);
        chk(flags_o[4] == 1'b0, "R3", {e.tag, " overflow flag"}, flags_o[4], 0);
        chk({flags_o[7], flags_o[3:0]} == {e.flags[7], e.flags[3:0]}, "R4",
            {e.tag, " kept flags"}, flags_o, e.flags);
        peek_addr_i = e.a_dst; #0.5;
        chk(peek_data_o == e.v_dst, "R5", {e.tag, " dst unchanged"}, peek_data_o, e.v_dst);
        peek_addr_i = e.a_src; #0.5;
        chk(peek_data_o == e.v_src, "R5", {e.tag, " src unchanged"}, peek_data_o, e.v_src);
        peek_addr_i = e.a_ptr; #0.5;
        chk(peek_data_o == e.v_ptr, "R5", {e.tag, " ptr unchanged"}, peek_data_o, e.v_ptr);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "R11", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rp_i = 8'h52; ins_valid_i = 1'b0; ins_byte_i = '0;
    ld_we_i = 1'b0; ld_addr_i = '0; ld_data_i = '0; peek_addr_i = '0;
    flag_we_i = 1'b0; flag_data_i = '0; exp_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(flags_o == 8'h00, "R12", "reset flags", flags_o, 0);
    chk(done_o == 1'b0, "R12", "reset done", done_o, 0);
    chk(ins_ready_o == 1'b1, "R12", "reset ready", ins_ready_o, 1);
    mon_on = 1'b1;

    for (int i = 12'h200; i < 12'h400; i++) poke(i[11:0], 8'((i * 37 + 11) & 8'hFF));
    poke(12'h253, 8'hF0); poke(12'h254, 8'h30);
    poke(12'h256, 8'h0F); poke(12'h257, 8'h81);
    poke(12'h258, 8'h90); poke(12'h290, 8'h0C);
    poke(12'h210, 8'hCF); poke(12'h220, 8'hE3);
    poke(12'h2E3, 8'h81);
    chk(1'b1, "R12", "preload", 0, 0);

    load_flags(8'h8D);
    // R6: working/working, all masked bits set -> zero
    run_op(8'h62, 8'h34, 8'h00, "R6 ww zero");
    run_op(8'h62, 8'h67, 8'h00, "R6 ww sign");
    run_op(8'h63, 8'h38, 8'h00, "R6 w/ind");
    // R7/R8: escaped mask register, plain destination
    run_op(8'h64, 8'hE4, 8'h10, "R7 R8 reg esc");
    // R9: pointer 0xE3 reaches plain location 0x2E3
    run_op(8'h65, 8'h20, 8'hE6, "R9 ind ptrE");
    peek_addr_i = 12'h2E3; #0.5;
    chk(peek_data_o == 8'h81, "R9", "plain E3 location", peek_data_o, 8'h81);
    run_op(8'h66, 8'h10, 8'hFF, "R7 imm");
    run_op(8'h67, 8'hE8, 8'h0C, "R7 ind imm");

    load_flags(8'h50);
    for (int k = 0; k < 8; k++) run_op(8'h66, 8'(k * 16 + 5), 8'(1 << k), "R1 imm sweep");
    load_flags(8'h00);
    run_op(8'h66, 8'h05, 8'h00, "R1 empty mask");

    // R10: illegal opcodes ignored
    begin
      logic [7:0] f0;
      int d0;
      f0 = flags_o; d0 = ndone;
      send(8'h61); send(8'h68); send(8'hFF);
      repeat (5) @(negedge clk);
      chk(flags_o == f0, "R10", "flags after illegal", flags_o, f0);
      chk(ndone == d0, "R10", "done after illegal", ndone, d0);
    end
    run_op(8'h66, 8'h10, 8'h30, "R10 resync");

    // R8: another pointer value
    rp_i = 8'hE3;
    for (int i = 12'h3E0; i < 12'h3F0; i++) poke(i[11:0], 8'(i ^ 8'h5A));
    load_flags(8'hAF);
    run_op(8'h62, 8'h12, 8'h00, "R8 rp change");
    run_op(8'h64, 8'hE7, 8'hE9, "R8 both esc");
    run_op(8'h67, 8'h40, 8'hA5, "R8 ind dst");

    drain();
    chk(ndone == nops, "R11", "done count", ndone, nops);
    chk(q.size() == 0, "R11", "pending results", q.size(), 0);
    finish_run();
  end

endmodule